// File: doc/BRIEF.md
# Control-Plane Pixel Source Selector

This block turns a three-plane frame buffer into a stream of 24-bit RGB pixels, one per clock. A raster address generator walks the visible rectangle with a line pitch of 1024 pixels whatever the visible width. Every generated address goes at the same time to three external synchronous memories: an 8-bit palette-index plane, a 32-bit direct-colour plane and a 32-bit per-pixel control plane. Each memory returns its word one clock later.

Plane words are stored with the most significant byte at the lowest address. The block therefore byte-reverses the control and direct-colour words before it looks at any field. The top byte of the reversed control word then chooses the pixel's source. One code value selects the direct-colour word. Every other value sends the index plane's byte through a 256-entry palette that is written through a port.

When the true-colour planes are switched off, the control word counts as zero and every pixel takes the palette path. A frame starts on a pulse and runs to completion. Each output pixel carries start-of-line and start-of-frame markers.

Top module: `cplane_pixel_sel`

## Requirements
- R1: After reset, mem_req, pix_valid, pix_sol and pix_sof are low. Palette entries 0 to 254 hold 0x000000 and entry 255 holds 0xFFFFFF.
- R2: When scan_start is accepted, mem_req is high for exactly width*height consecutive clocks and then goes low. mem_addr is y*1024+x, with x running from 0 to width-1 fastest and y running from 0 to height-1. The pitch stays 1024 for any width, and the largest frame is 1024 by 768.
- R3: scan_start is ignored while width or height is zero, and it is ignored while a scan is running. In both cases the address sequence and the pixel count are unchanged.
- R4: Plane data is expected on the read-data inputs one clock after its address. The pixel for each address appears with pix_valid exactly 3 clocks after that address was presented with mem_req.
- R5: pix_sol is high on the output pixel for x = 0. pix_sof is high only on the output pixel for x = 0, y = 0.
- R6: With true_colour_en high, let the control word's byte ctl_rdata[7:0] equal 0x03. This byte is the top byte after reversal. The output is then the reversed direct word's low 24 bits: red = dcol_rdata[15:8], green = dcol_rdata[23:16], blue = dcol_rdata[31:24]. pix_rgb packs red in [23:16], green in [15:8] and blue in [7:0].
- R7: With true_colour_en high and any other value in ctl_rdata[7:0], the output is the palette entry addressed by idx_rdata. This holds even when ctl_rdata[31:24] is 0x03.
- R8: With true_colour_en low, every pixel is the palette entry addressed by idx_rdata, whatever the control word.
- R9: A clock with pal_wr_en high stores pal_wr_rgb into entry pal_wr_idx. Pixels looked up afterwards return the new value, and the other entries are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_start | input | 1 | Pulse that starts one frame scan |
| vis_width | input | 11 | Visible width in pixels, 1 to 1024 |
| vis_height | input | 10 | Visible height in lines, 1 to 768 |
| true_colour_en | input | 1 | Enables the direct-colour and control planes |
| pal_wr_en | input | 1 | Palette write strobe |
| pal_wr_idx | input | 8 | Palette entry to write |
| pal_wr_rgb | input | 24 | Colour to write, red in [23:16] |
| mem_req | output | 1 | Plane read request for mem_addr |
| mem_addr | output | 20 | Linear pixel address y*1024+x |
| idx_rdata | input | 8 | Index plane byte, one clock after the address |
| dcol_rdata | input | 32 | Direct-colour word as stored, one clock after the address |
| ctl_rdata | input | 32 | Control word as stored, one clock after the address |
| pix_valid | output | 1 | Output pixel valid |
| pix_sol | output | 1 | Output pixel is the first of a line |
| pix_sof | output | 1 | Output pixel is the first of a frame |
| pix_rgb | output | 24 | Output colour |

## Verification
The hardest case to reach from the ports is a control word that looks direct only when its bytes are read in the wrong order. A pixel of that kind must still be reported as palette-sourced. The bench memory model gives such words, with 0x03 in the stored top byte, to a share of the addresses. It mixes them with words carrying 0x03 in the byte that truly decides, and with words carrying decoy codes 0x02 and 0x83. The mix depends on both x and y, so it shifts from line to line.

A second hard case is the palette's reset image, which has to be observed before the first palette write. The very first frame therefore scans 256 pixels of line 0, where the index equals x, and the true-colour planes are off.

// File: rtl/cplane_pkg.sv
package cplane_pkg;

    localparam int X_BITS     = 10;
    localparam int Y_BITS     = 10;
    localparam int MAX_LINES  = 768;
    localparam int IDX_W      = 8;
    localparam int CH_W       = 8;
    localparam int WORD_W     = 32;
    localparam int MEM_LAT    = 1;
    localparam logic [7:0] DIRECT_CODE = 8'h03;

    typedef struct packed {
        logic [CH_W-1:0] r;
        logic [CH_W-1:0] g;
        logic [CH_W-1:0] b;
    } rgb_t;

    typedef struct packed {
        logic valid;
        logic sol;
        logic sof;
    } mark_t;

    function automatic logic [WORD_W-1:0] swap_bytes(input logic [WORD_W-1:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

endpackage

// File: rtl/raster_addr_gen.sv
module raster_addr_gen
    import cplane_pkg::*;
#(
    parameter int XB = X_BITS,
    parameter int YB = Y_BITS,
    parameter int HL = MAX_LINES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [XB:0]      width,
    input  logic [YB-1:0]    height,
    output logic             req,
    output logic [XB+YB-1:0] addr,
    output mark_t            mark
);
    localparam int STRIDE = 1 << XB;
    localparam logic [XB:0]   W_MAX = (XB+1)'(STRIDE);
    localparam logic [YB-1:0] H_MAX = YB'(HL);

    logic          active_q;
    logic [XB-1:0] x_q, x_last_q;
    logic [YB-1:0] y_q, y_last_q;
    logic [XB:0]   w_eff;
    logic [YB-1:0] h_eff;
    logic          go;

    always_comb begin
        w_eff = (width > W_MAX) ? W_MAX : width;
        h_eff = (height > H_MAX) ? H_MAX : height;
        go    = start && !active_q && (w_eff != '0) && (h_eff != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            x_q      <= '0;
            y_q      <= '0;
            x_last_q <= '0;
            y_last_q <= '0;
        end else if (!active_q) begin
            if (go) begin
                active_q <= 1'b1;
                x_q      <= '0;
                y_q      <= '0;
                x_last_q <= XB'(w_eff - 1'b1);
                y_last_q <= h_eff - 1'b1;
            end
        end else if (x_q == x_last_q) begin
            x_q <= '0;
            if (y_q == y_last_q) begin
                active_q <= 1'b0;
            end else begin
                y_q <= y_q + 1'b1;
            end
        end else begin
            x_q <= x_q + 1'b1;
        end
    end

    always_comb begin
        req        = active_q;
        addr       = {y_q, x_q};
        mark.valid = active_q;
        mark.sol   = active_q && (x_q == '0);
        mark.sof   = active_q && (x_q == '0) && (y_q == '0);
    end

endmodule

// File: rtl/plane_decode.sv
module plane_decode
    import cplane_pkg::*;
#(
    parameter int IW = IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tc_en,
    input  mark_t             mark_in,
    input  logic [IW-1:0]     idx_in,
    input  logic [WORD_W-1:0] dcol_in,
    input  logic [WORD_W-1:0] ctl_in,
    output mark_t             mark_out,
    output logic              direct_out,
    output rgb_t              rgb_out,
    output logic [IW-1:0]     idx_out
);
    logic [WORD_W-1:0] ctl_s, dcol_s;
    logic              is_direct;
    logic [31:0]       unused_bits;

    always_comb begin
        ctl_s       = tc_en ? swap_bytes(ctl_in) : '0;
        dcol_s      = swap_bytes(dcol_in);
        is_direct   = (ctl_s[31:24] == DIRECT_CODE);
        unused_bits = {dcol_s[31:24], ctl_s[23:0]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mark_out   <= '0;
            direct_out <= 1'b0;
            rgb_out    <= '0;
            idx_out    <= '0;
        end else begin
            mark_out   <= mark_in;
            direct_out <= is_direct;
            rgb_out    <= rgb_t'(dcol_s[23:0]);
            idx_out    <= idx_in;
        end
    end

endmodule

// File: rtl/colour_palette.sv
module colour_palette
    import cplane_pkg::*;
#(
    parameter int IW = IDX_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  rgb_t          wr_rgb,
    input  logic [IW-1:0] rd_idx,
    output rgb_t          rd_rgb
);
    localparam int DEPTH = 1 << IW;

    rgb_t ent [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                ent[i] <= (i == DEPTH - 1) ? '1 : '0;
            end
            rd_rgb <= '0;
        end else begin
            if (wr_en) begin
                ent[wr_idx] <= wr_rgb;
            end
            rd_rgb <= ent[rd_idx];
        end
    end

endmodule

// File: rtl/cplane_pixel_sel.sv
module cplane_pixel_sel
    import cplane_pkg::*;
#(
    parameter int XB = X_BITS,
    parameter int YB = Y_BITS,
    parameter int IW = IDX_W,
    parameter int ML = MEM_LAT
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   scan_start,
    input  logic [XB:0]            vis_width,
    input  logic [YB-1:0]          vis_height,
    input  logic                   true_colour_en,
    input  logic                   pal_wr_en,
    input  logic [IW-1:0]          pal_wr_idx,
    input  logic [3*CH_W-1:0]      pal_wr_rgb,
    output logic                   mem_req,
    output logic [XB+YB-1:0]       mem_addr,
    input  logic [IW-1:0]          idx_rdata,
    input  logic [WORD_W-1:0]      dcol_rdata,
    input  logic [WORD_W-1:0]      ctl_rdata,
    output logic                   pix_valid,
    output logic                   pix_sol,
    output logic                   pix_sof,
    output logic [3*CH_W-1:0]      pix_rgb
);
    mark_t         mark_a;
    mark_t         mark_dly [ML];
    mark_t         mark_d, mark_o;
    logic          direct_d, direct_o;
    rgb_t          rgb_d, rgb_o, pal_rgb;
    logic [IW-1:0] idx_d;

    raster_addr_gen #(.XB(XB), .YB(YB)) u_scan (
        .clk    (clk),
        .rst    (rst),
        .start  (scan_start),
        .width  (vis_width),
        .height (vis_height),
        .req    (mem_req),
        .addr   (mem_addr),
        .mark   (mark_a)
    );

    // Markers wait for the external read latency.
    generate
        for (genvar k = 0; k < ML; k++) begin : g_mdly
            always_ff @(posedge clk) begin
                if (rst) begin
                    mark_dly[k] <= '0;
                end else if (k == 0) begin
                    mark_dly[k] <= mark_a;
                end else begin
                    mark_dly[k] <= mark_dly[(k == 0) ? 0 : k-1];
                end
            end
        end
    endgenerate

    plane_decode #(.IW(IW)) u_dec (
        .clk        (clk),
        .rst        (rst),
        .tc_en      (true_colour_en),
        .mark_in    (mark_dly[ML-1]),
        .idx_in     (idx_rdata),
        .dcol_in    (dcol_rdata),
        .ctl_in     (ctl_rdata),
        .mark_out   (mark_d),
        .direct_out (direct_d),
        .rgb_out    (rgb_d),
        .idx_out    (idx_d)
    );

    colour_palette #(.IW(IW)) u_pal (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (pal_wr_en),
        .wr_idx (pal_wr_idx),
        .wr_rgb (rgb_t'(pal_wr_rgb)),
        .rd_idx (idx_d),
        .rd_rgb (pal_rgb)
    );

    // Stage alongside the palette read keeps the choice aligned.
    always_ff @(posedge clk) begin
        if (rst) begin
            mark_o   <= '0;
            direct_o <= 1'b0;
            rgb_o    <= '0;
        end else begin
            mark_o   <= mark_d;
            direct_o <= direct_d;
            rgb_o    <= rgb_d;
        end
    end

    always_comb begin
        pix_valid = mark_o.valid;
        pix_sol   = mark_o.sol;
        pix_sof   = mark_o.sof;
        pix_rgb   = direct_o ? rgb_o : pal_rgb;
    end

endmodule

// File: rtl/cplane_pixel_sel_chk.sv
module cplane_pixel_sel_chk
    import cplane_pkg::*;
#(
    parameter int XB = X_BITS,
    parameter int YB = Y_BITS
) (
    input logic             clk,
    input logic             rst,
    input logic             mem_req,
    input logic [XB+YB-1:0] mem_addr,
    input logic             pix_valid,
    input logic             pix_sol,
    input logic             pix_sof
);
    // R4: the default read latency of one clock gives three clocks end to end
    p_latency_r4: assert property (@(posedge clk) disable iff (rst)
        pix_valid == $past(mem_req, 3));

    // R2: x advances by one inside a line
    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        (mem_req && $past(mem_req) && mem_addr[XB-1:0] != '0)
        |-> mem_addr == $past(mem_addr) + (XB+YB)'(1));

    // R2: a new line inside a scan moves one full pitch in y
    p_line_r2: assert property (@(posedge clk) disable iff (rst)
        (mem_req && $past(mem_req) && mem_addr[XB-1:0] == '0)
        |-> mem_addr[XB+YB-1:XB] == $past(mem_addr[XB+YB-1:XB]) + YB'(1));

    // R5: line marker only on valid pixels
    p_sol_r5: assert property (@(posedge clk) disable iff (rst)
        pix_sol |-> pix_valid);

    // R5: frame marker is also a line marker
    p_sof_r5: assert property (@(posedge clk) disable iff (rst)
        pix_sof |-> (pix_sol && pix_valid));

endmodule

bind cplane_pixel_sel cplane_pixel_sel_chk #(.XB(XB), .YB(YB)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .pix_valid (pix_valid),
    .pix_sol   (pix_sol),
    .pix_sof   (pix_sof)
);

// File: tb/cplane_pixel_sel_bench.sv
`timescale 1ns/1ps
module cplane_pixel_sel_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scan_start = 1'b0;
    logic [10:0] vis_width = '0;
    logic [9:0]  vis_height = '0;
    logic        true_colour_en = 1'b0;
    logic        pal_wr_en = 1'b0;
    logic [7:0]  pal_wr_idx = '0;
    logic [23:0] pal_wr_rgb = '0;
    logic        mem_req;
    logic [19:0] mem_addr;
    logic [7:0]  idx_rdata;
    logic [31:0] dcol_rdata;
    logic [31:0] ctl_rdata;
    logic        pix_valid, pix_sol, pix_sof;
    logic [23:0] pix_rgb;

    always #2 clk = ~clk;

    cplane_pixel_sel u_cplane_pixel_sel (.*);

    integer n_chk = 0;
    integer n_fail = 0;
    logic [23:0] pal_m [0:255];

    integer cur_w = 0, cur_mode = 0;
    integer ax = 0, ay = 0, px = 0, py = 0;
    integer n_req = 0, n_pix = 0;
    logic [2:0] hist = '0;

    function automatic logic [7:0] idx_fn(input logic [19:0] a);
        return a[7:0] ^ {a[13:10], a[17:14]};
    endfunction

    function automatic logic [31:0] ctl_fn(input logic [19:0] a);
        case (a[1:0] ^ a[11:10])
            2'd0:    return 32'h0000_0003;
            2'd1:    return 32'h0300_0000;
            2'd2:    return 32'h0000_0002;
            default: return 32'h0300_0083;
        endcase
    endfunction

    function automatic logic [31:0] dcol_fn(input logic [19:0] a);
        return {a[7:0] ^ 8'h5A, a[15:8] ^ 8'h3C, a[19:12] ^ a[7:0], 8'hA5};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // memory model: one clock read latency
    always @(posedge clk) begin
        idx_rdata  <= idx_fn(mem_addr);
        dcol_rdata <= dcol_fn(mem_addr);
        ctl_rdata  <= ctl_fn(mem_addr);
    end

    // monitor
    always @(negedge clk) begin
        if (rst) begin
            hist = '0;
        end else begin
            if (pix_valid || hist[2])
                chk(pix_valid == hist[2], "R4 valid latency", {31'd0, pix_valid}, {31'd0, hist[2]});
            hist = {hist[1:0], mem_req};
            if (mem_req) begin
                chk(mem_addr == 20'(ay * 1024 + ax), "R2 address", {12'd0, mem_addr}, ay * 1024 + ax);
                n_req++;
                if (ax == cur_w - 1) begin ax = 0; ay++; end else ax++;
            end
            if (pix_valid) begin
                logic [19:0] a;
                logic [31:0] c, d;
                logic [23:0] e;
                string tg;
                a = 20'(py * 1024 + px);
                c = ctl_fn(a);
                d = dcol_fn(a);
                if (cur_mode != 0 && c[7:0] == 8'h03) begin
                    e = {d[15:8], d[23:16], d[31:24]};
                    tg = "R6 direct pixel";
                end else begin
                    e = pal_m[idx_fn(a)];
                    tg = (cur_mode != 0) ? "R7 palette pixel" : "R8 palette-only pixel";
                end
                chk(pix_rgb == e, tg, {8'd0, pix_rgb}, {8'd0, e});
                chk(pix_sol == (px == 0), "R5 sol", {31'd0, pix_sol}, {31'd0, px == 0});
                chk(pix_sof == (px == 0 && py == 0), "R5 sof", {31'd0, pix_sof}, {31'd0, px == 0 && py == 0});
                n_pix++;
                if (px == cur_w - 1) begin px = 0; py++; end else px++;
            end
        end
    end

    task automatic run_frame(input integer w, input integer h, input integer mode,
                             input integer extra, input string tag);
        integer total;
        total = (w == 0 || h == 0) ? 0 : w * h;
        @(negedge clk);
        cur_w = w; cur_mode = mode;
        ax = 0; ay = 0; px = 0; py = 0; n_req = 0; n_pix = 0;
        vis_width = 11'(w); vis_height = 10'(h); true_colour_en = (mode != 0);
        scan_start = 1'b1;
        for (int i = 0; i < total + 12; i++) begin
            @(negedge clk);
            scan_start = (extra > 0 && i == extra);
        end
        scan_start = 1'b0;
        chk(n_req == total, tag, n_req, total);
        chk(n_pix == total, tag, n_pix, total);
    endtask

    task automatic pal_write(input logic [7:0] i, input logic [23:0] v);
        @(negedge clk);
        pal_wr_en = 1'b1; pal_wr_idx = i; pal_wr_rgb = v;
        @(negedge clk);
        pal_wr_en = 1'b0;
        pal_m[i] = v;
    endtask

    // width, height, mode
    localparam logic [21:0] VEC [0:5] = '{
        {11'd8,    10'd4, 1'b1},
        {11'd3,    10'd5, 1'b0},
        {11'd17,   10'd2, 1'b1},
        {11'd1,    10'd3, 1'b1},
        {11'd6,    10'd1, 1'b0},
        {11'd1024, 10'd2, 1'b1}
    };

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R2: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) pal_m[i] = (i == 255) ? 24'hFFFFFF : 24'h000000;
        repeat (4) @(negedge clk);
        chk({mem_req, pix_valid, pix_sol, pix_sof} == 4'b0, "R1 outputs in reset",
            {28'd0, mem_req, pix_valid, pix_sol, pix_sof}, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk({mem_req, pix_valid, pix_sol, pix_sof} == 4'b0, "R1 outputs after reset",
            {28'd0, mem_req, pix_valid, pix_sol, pix_sof}, 0);

        // R1: reset palette seen through line 0 where index equals x
        run_frame(256, 1, 0, 0, "R1 reset palette frame count");

        // R3: zero dimensions start nothing
        run_frame(0, 3, 1, 0, "R3 zero width");
        run_frame(5, 0, 1, 0, "R3 zero height");

        // R9: fill palette
        for (int i = 0; i < 256; i++)
            pal_write(8'(i), {8'(i), ~8'(i), 8'(i) ^ 8'h55});

        for (int v = 0; v < 6; v++)
            run_frame(VEC[v][21:11], VEC[v][10:1], VEC[v][0], 0, "R2 frame count");

        // R3: second start during a scan is ignored
        run_frame(4, 3, 1, 5, "R3 restart ignored");

        // R9: rewrite a few entries and see them at line 0
        for (int i = 0; i < 8; i++)
            pal_write(8'(i), 24'h102030 + 24'(i * 24'h010101));
        run_frame(8, 1, 0, 0, "R9 rewritten palette frame count");

        summary();
        $finish;
    end

endmodule